// File: doc/BRIEF.md
# PHY Address Auto-Detect Scanner

This block sits in front of an MDIO management engine and locates the PHY attached to it. A one-cycle start pulse arms it. If the caller has a likely address, it supplies that address with a qualifying flag, and the scanner reads that address first. When that read gives a plausible PHY answer, the search ends at once. When it does not, or when no preferred address is given, the scanner walks the whole address space from the highest address down to zero. It stops at the first device that answers plausibly.

Each probe is a read of the PHY basic status register. A device counts as present when two things hold. First, the returned word must not be all ones, which is what a floating management bus returns. Second, the word must show all three capability bits the scanner requires. The scanner talks to the engine through a request pulse, a busy level and a read-data word. When the search ends it raises a done flag and holds it. With done it gives either the address found and a success flag, or a cleared success flag meaning nothing was detected.

Top module: `phy_addr_scanner`

## Requirements
- R1: After reset, `scan_done`, `phy_found` and `mgmt_req` are all low.
- R2: Every request issued to the engine carries register number 1 on `mgmt_reg`.
- R3: A response counts as valid only when it is not 16'hFFFF and has bits 12, 11 and 3 all set (mask 16'h1808); any other word, including 16'hFFFF, is treated as no device.
- R4: When `pref_valid` is high at start, the first probe targets `pref_addr`; if that probe is valid the search ends after exactly one probe and reports that address.
- R5: When the preferred probe is invalid, or no preferred address is given, probes follow the order 31, 30, ..., 0, one per address.
- R6: The first valid response ends the search: `scan_done` rises with `phy_found` high and `phy_addr` equal to the probed address, and no further request is issued.
- R7: If no address among the 32 responds validly, `scan_done` rises with `phy_found` low after the probe of address 0.
- R8: `mgmt_req` is a single-cycle pulse, asserted only while `mgmt_busy` is low; the read data is taken when busy falls after the request.
- R9: `scan_done`, `phy_found` and `phy_addr` hold their values until the next accepted start; a start pulse during a search is ignored and does not change the probe sequence or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that arms a new search when idle or finished |
| pref_valid | input | 1 | Qualifies `pref_addr` at start |
| pref_addr | input | 5 | Address to try before the full scan |
| mgmt_req | output | 1 | One-cycle read request to the MDIO engine |
| mgmt_phy | output | 5 | PHY address of the current request |
| mgmt_reg | output | 5 | Register number of the current request |
| mgmt_busy | input | 1 | Engine busy level |
| mgmt_rdata | input | 16 | Read data, valid when busy falls |
| scan_done | output | 1 | Search finished; held until the next start |
| phy_found | output | 1 | A valid PHY was found |
| phy_addr | output | 5 | Address of the PHY found |

## Verification
Random response maps give each address a floating-bus all-ones word, a near-miss word missing one capability bit, a valid word or an arbitrary word. These are paired with random preferred addresses and random engine latencies. The bench compares the full probe order, the probe count and the result against a model. Directed maps cover cases that each catch a different fault: an empty bus, which tells a scan that stops early or wraps from one that ends cleanly at zero; a device at address 0 only, which checks the floor; and a near-miss word next to a valid one, which tells the mask test from a test that only rejects all ones. A preferred hit versus a preferred miss shows whether the preferred result short-circuits the scan. A busy level held before the first request, and a start pulse during a search, check the handshake and the re-arm rule.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam int          PHY_ADDR_W   = 5;
    localparam int          MGMT_DATA_W  = 16;
    localparam int          MGMT_REG_W   = 5;
    localparam logic [4:0]  BMSR_REG_NUM = 5'd1;
    localparam logic [15:0] ABILITY_MASK = 16'h1808;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_WAIT_FREE,
        SC_ISSUE,
        SC_WAIT_ACK,
        SC_WAIT_END,
        SC_JUDGE,
        SC_DONE
    } scan_state_e;

    // A floating bus reads as all ones; a real PHY shows every required ability bit.
    function automatic logic resp_plausible(input logic [MGMT_DATA_W-1:0] word,
                                            input logic [MGMT_DATA_W-1:0] mask);
        return (word != '1) && ((word & mask) == mask);
    endfunction

endpackage

// File: rtl/phy_resp_latch.sv
module phy_resp_latch
    import phy_scan_pkg::*;
#(
    parameter int               DATA_W = MGMT_DATA_W,
    parameter logic [DATA_W-1:0] MASK  = ABILITY_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata,
    output logic              resp_valid
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '1;
        end else if (capture) begin
            held_q <= rdata;
        end
    end

    assign resp_valid = resp_plausible(held_q, MASK);

endmodule

// File: rtl/phy_addr_cursor.sv
module phy_addr_cursor #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_start,
    input  logic              use_pref,
    input  logic [ADDR_W-1:0] pref_addr,
    input  logic              load_top,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              from_pref,
    output logic              at_floor
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [ADDR_W-1:0] addr_q;
    logic              pref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= TOP_ADDR;
            pref_q <= 1'b0;
        end else if (load_start) begin
            addr_q <= use_pref ? pref_addr : TOP_ADDR;
            pref_q <= use_pref;
        end else if (load_top) begin
            addr_q <= TOP_ADDR;
            pref_q <= 1'b0;
        end else if (step) begin
            addr_q <= addr_q - 1'b1;
        end
    end

    assign addr      = addr_q;
    assign from_pref = pref_q;
    assign at_floor  = (addr_q == '0);

    a_r5_no_wrap_below_floor: assert property (@(posedge clk) disable iff (rst)
        step |-> !at_floor);

    a_r5_step_after_full_scan_start: assert property (@(posedge clk) disable iff (rst)
        step |-> !from_pref);

endmodule

// File: rtl/phy_scan_fsm.sv
module phy_scan_fsm
    import phy_scan_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mgmt_busy,
    input  logic              resp_valid,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              from_pref,
    input  logic              at_floor,
    output logic              mgmt_req,
    output logic              capture,
    output logic              load_start,
    output logic              load_top,
    output logic              step,
    output logic              scan_done,
    output logic              phy_found,
    output logic [ADDR_W-1:0] phy_addr
);

    scan_state_e       state_q, state_d;
    logic              done_q, found_q;
    logic [ADDR_W-1:0] result_q;
    logic              judge_hit, judge_fail;

    assign load_start = start && ((state_q == SC_IDLE) || (state_q == SC_DONE));
    assign mgmt_req   = (state_q == SC_ISSUE);
    assign capture    = (state_q == SC_WAIT_END) && !mgmt_busy;
    assign judge_hit  = (state_q == SC_JUDGE) && resp_valid;
    assign judge_fail = (state_q == SC_JUDGE) && !resp_valid;
    assign load_top   = judge_fail && from_pref;
    assign step       = judge_fail && !from_pref && !at_floor;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE, SC_DONE: if (load_start) state_d = SC_WAIT_FREE;
            SC_WAIT_FREE:     if (!mgmt_busy) state_d = SC_ISSUE;
            SC_ISSUE:         state_d = SC_WAIT_ACK;
            SC_WAIT_ACK:      if (mgmt_busy) state_d = SC_WAIT_END;
            SC_WAIT_END:      if (!mgmt_busy) state_d = SC_JUDGE;
            SC_JUDGE: begin
                if (judge_hit || (!from_pref && at_floor)) state_d = SC_DONE;
                else                                       state_d = SC_WAIT_FREE;
            end
            default:          state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SC_IDLE;
            done_q   <= 1'b0;
            found_q  <= 1'b0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_start) begin
                done_q  <= 1'b0;
                found_q <= 1'b0;
            end else if (judge_hit) begin
                done_q   <= 1'b1;
                found_q  <= 1'b1;
                result_q <= cur_addr;
            end else if (judge_fail && !from_pref && at_floor) begin
                done_q  <= 1'b1;
                found_q <= 1'b0;
            end
        end
    end

    assign scan_done = done_q;
    assign phy_found = found_q;
    assign phy_addr  = result_q;

    a_r8_req_only_when_free: assert property (@(posedge clk) disable iff (rst)
        mgmt_req |-> !mgmt_busy);

    a_r8_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mgmt_req |=> !mgmt_req);

    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (scan_done && !start) |=> scan_done);

    a_r9_addr_holds: assert property (@(posedge clk) disable iff (rst)
        (scan_done && !start) |=> $stable(phy_addr) && $stable(phy_found));

    a_r6_found_implies_done: assert property (@(posedge clk) disable iff (rst)
        phy_found |-> scan_done);

    a_r3_found_needs_valid_resp: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_found) |-> $past(resp_valid));

    a_r6_no_req_after_done: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !mgmt_req);

endmodule

// File: rtl/phy_addr_scanner.sv
module phy_addr_scanner
    import phy_scan_pkg::*;
#(
    parameter int                ADDR_W     = PHY_ADDR_W,
    parameter int                DATA_W     = MGMT_DATA_W,
    parameter int                REG_W      = MGMT_REG_W,
    parameter logic [REG_W-1:0]  STATUS_REG = BMSR_REG_NUM,
    parameter logic [DATA_W-1:0] MASK       = ABILITY_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pref_valid,
    input  logic [ADDR_W-1:0] pref_addr,
    output logic              mgmt_req,
    output logic [ADDR_W-1:0] mgmt_phy,
    output logic [REG_W-1:0]  mgmt_reg,
    input  logic              mgmt_busy,
    input  logic [DATA_W-1:0] mgmt_rdata,
    output logic              scan_done,
    output logic              phy_found,
    output logic [ADDR_W-1:0] phy_addr
);

    logic              capture, resp_valid;
    logic              load_start, load_top, step;
    logic [ADDR_W-1:0] cur_addr;
    logic              from_pref, at_floor;

    phy_resp_latch #(
        .DATA_W (DATA_W),
        .MASK   (MASK)
    ) u_latch (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .rdata      (mgmt_rdata),
        .resp_valid (resp_valid)
    );

    phy_addr_cursor #(
        .ADDR_W (ADDR_W)
    ) u_cursor (
        .clk        (clk),
        .rst        (rst),
        .load_start (load_start),
        .use_pref   (pref_valid),
        .pref_addr  (pref_addr),
        .load_top   (load_top),
        .step       (step),
        .addr       (cur_addr),
        .from_pref  (from_pref),
        .at_floor   (at_floor)
    );

    phy_scan_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mgmt_busy  (mgmt_busy),
        .resp_valid (resp_valid),
        .cur_addr   (cur_addr),
        .from_pref  (from_pref),
        .at_floor   (at_floor),
        .mgmt_req   (mgmt_req),
        .capture    (capture),
        .load_start (load_start),
        .load_top   (load_top),
        .step       (step),
        .scan_done  (scan_done),
        .phy_found  (phy_found),
        .phy_addr   (phy_addr)
    );

    assign mgmt_phy = cur_addr;
    assign mgmt_reg = STATUS_REG;

    a_r2_req_targets_status_reg: assert property (@(posedge clk) disable iff (rst)
        mgmt_req |-> (mgmt_reg == 5'd1));

    a_r8_phy_stable_while_busy: assert property (@(posedge clk) disable iff (rst)
        (mgmt_busy && !scan_done && !start) |=> $stable(mgmt_phy));

endmodule

// File: tb/test_phy_addr_scanner.sv
module test_phy_addr_scanner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pref_valid = 1'b0;
    logic [4:0]  pref_addr = '0;
    logic        mgmt_req;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic        mgmt_busy;
    logic [15:0] mgmt_rdata;
    logic        scan_done, phy_found;
    logic [4:0]  phy_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    phy_addr_scanner i_phy_addr_scanner (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pref_valid (pref_valid),
        .pref_addr  (pref_addr),
        .mgmt_req   (mgmt_req),
        .mgmt_phy   (mgmt_phy),
        .mgmt_reg   (mgmt_reg),
        .mgmt_busy  (mgmt_busy),
        .mgmt_rdata (mgmt_rdata),
        .scan_done  (scan_done),
        .phy_found  (phy_found),
        .phy_addr   (phy_addr)
    );

    // MDIO engine model
    logic [15:0] model [32];
    int          lat_cfg = 0;
    logic        ext_busy = 1'b0;
    logic        eng_busy = 1'b0;
    int          eng_cnt = 0;
    logic [4:0]  eng_addr = '0;
    logic [15:0] rdata_q = 16'h0000;
    logic        log_clr = 1'b0;
    int          n_probe = 0;
    logic [4:0]  probe_log [64];
    int          bad_req = 0;
    int          bad_reg = 0;

    assign mgmt_busy  = eng_busy | ext_busy;
    assign mgmt_rdata = rdata_q;

    always @(posedge clk) begin
        if (log_clr) begin
            n_probe <= 0;
            bad_req <= 0;
            bad_reg <= 0;
        end else if (mgmt_req) begin
            if (n_probe < 64) probe_log[n_probe] <= mgmt_phy;
            n_probe <= n_probe + 1;
            if (mgmt_busy) bad_req <= bad_req + 1;
            if (mgmt_reg != 5'd1) bad_reg <= bad_reg + 1;
        end
        if (mgmt_req && !eng_busy) begin
            eng_busy <= 1'b1;
            eng_cnt  <= lat_cfg;
            eng_addr <= mgmt_phy;
        end else if (eng_busy) begin
            if (eng_cnt == 0) begin
                eng_busy <= 1'b0;
                rdata_q  <= model[eng_addr];
            end else begin
                eng_cnt <= eng_cnt - 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual=expired expected=finished");
            n_bad = n_bad + 1;
            n_cmp = n_cmp + 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic bit is_phy(input logic [15:0] v);
        return (v != 16'hFFFF) && (v[12] && v[11] && v[3]);
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] v);
        for (int i = 0; i < 32; i++) model[i] = v;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 32; i++) begin
            int unsigned r = $urandom % 12;
            logic [15:0] w = 16'($urandom);
            if (r < 7)       model[i] = 16'hFFFF;
            else if (r == 7) model[i] = (w | 16'h1808) & ~16'h0800;
            else if (r == 8) model[i] = (w | 16'h1808) & 16'h7FFF;
            else if (r == 9) model[i] = w & 16'hE7F7;
            else             model[i] = w;
        end
    endtask

    task automatic run_trial(input bit pv, input logic [4:0] pa,
                             input int lat, input int ebusy, input bit mid);
        logic [4:0] exp_list [64];
        int  n_exp = 0;
        bit  exp_found = 1'b0;
        logic [4:0] exp_addr = '0;
        int  first_diff = -1;
        int  c;
        if (pv) begin
            exp_list[n_exp] = pa; n_exp++;
            if (is_phy(model[pa])) begin exp_found = 1'b1; exp_addr = pa; end
        end
        if (!exp_found) begin
            for (int a = 31; a >= 0; a--) begin
                exp_list[n_exp] = 5'(a); n_exp++;
                if (is_phy(model[a])) begin exp_found = 1'b1; exp_addr = 5'(a); break; end
            end
        end
        @(negedge clk);
        lat_cfg    = lat;
        pref_valid = pv;
        pref_addr  = pa;
        log_clr    = 1'b1;
        ext_busy   = (ebusy > 0);
        start      = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start   = 1'b0;
        pref_valid = ~pv;
        pref_addr  = ~pa;
        c = 0;
        while (!scan_done && c < 3000) begin
            ext_busy = (c < ebusy);
            start = (mid && n_exp >= 3 && c == 6);
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        ext_busy = 1'b0;
        check("R6/R7 done reached", scan_done == 1'b1, int'(scan_done), 1);
        check(exp_found ? "R6 found flag" : "R7 not-detected flag",
              phy_found == exp_found, int'(phy_found), int'(exp_found));
        if (exp_found)
            check(pv && n_exp == 1 ? "R4 preferred address reported" : "R6 address reported",
                  phy_addr == exp_addr, int'(phy_addr), int'(exp_addr));
        check(pv ? "R4/R5 probe count" : "R5 probe count", n_probe == n_exp, n_probe, n_exp);
        for (int i = 0; i < n_exp && i < n_probe; i++)
            if (first_diff < 0 && probe_log[i] != exp_list[i]) first_diff = i;
        if (first_diff >= 0)
            check("R5 probe order", 1'b0, int'(probe_log[first_diff]), int'(exp_list[first_diff]));
        else
            check("R5 probe order", 1'b1, 0, 0);
        check("R8 request while busy", bad_req == 0, bad_req, 0);
        check("R2 register number", bad_reg == 0, bad_reg, 0);
        for (int i = 0; i < 8; i++) @(negedge clk);
        check("R9 done held", scan_done == 1'b1 && phy_found == exp_found
              && (!exp_found || phy_addr == exp_addr), int'(phy_addr), int'(exp_addr));
    endtask

    initial begin
        void'($urandom(32'd7321));
        fill(16'hFFFF);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset done", scan_done == 1'b0, int'(scan_done), 0);
        check("R1 reset found", phy_found == 1'b0, int'(phy_found), 0);
        check("R1 reset req", mgmt_req == 1'b0, int'(mgmt_req), 0);

        // R7: empty bus, full scan to zero, nothing found
        fill(16'hFFFF);
        run_trial(1'b0, 5'd0, 1, 0, 1'b0);
        // R7: preferred given, empty bus -> 33 probes
        run_trial(1'b1, 5'd9, 0, 0, 1'b0);
        // R6 floor: device only at address 0
        fill(16'hFFFF); model[0] = 16'h1808;
        run_trial(1'b0, 5'd0, 2, 3, 1'b1);
        // R4: preferred hit skips scan
        fill(16'hFFFF); model[5] = 16'h796D; model[31] = 16'h7809;
        run_trial(1'b1, 5'd5, 1, 0, 1'b0);
        // R4/R5: preferred miss then scan from 31
        run_trial(1'b1, 5'd6, 3, 2, 1'b0);
        // R3: near-miss word and all-ones rejected, valid one accepted
        fill(16'hFFFF); model[31] = 16'h1800; model[30] = 16'h0808; model[29] = 16'hFFFF;
        model[28] = 16'h1008; model[27] = 16'h1808; model[26] = 16'h7809;
        run_trial(1'b1, 5'd31, 0, 0, 1'b1);
        // R4: preferred flag low means pref_addr is ignored
        run_trial(1'b0, 5'd26, 0, 0, 1'b0);

        for (int t = 0; t < 40; t++) begin
            fill_random();
            run_trial(1'($urandom % 2), 5'($urandom), int'($urandom % 4),
                      int'($urandom % 4), 1'($urandom % 2));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule